// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block turns the status of a 16550-style serial controller into the single interrupt request line and the byte that software reads to find out why it was interrupted. It takes the enable register, line status bits, the receive-FIFO fill count and trigger level, the FIFO-enable bit, the character-timeout pending flag and the modem status delta bits. From these it picks the most urgent enabled source under a fixed five-level priority. It registers the chosen identifier together with the FIFO status bits and registers the interrupt line beside it.

The block owns the enable register and the transmit-empty pending flag. That flag is held by a two-state machine: `TP_IDLE` (nothing owed) and `TP_ARMED` (an empty-holding-register interrupt is owed). It moves `TP_IDLE -> TP_ARMED` on an arm event, which is either a transmitter-emptied pulse or an enable write while the holding register is empty. It moves `TP_ARMED -> TP_IDLE` on a holding-register load, or when software reads the identification byte while that byte reports the empty source. If an arm event and an acknowledge fall in the same cycle, the machine stays in `TP_ARMED`. A load always forces `TP_IDLE`.

Top module: `uart_iid_enc`

## Requirements
- R1: A write to the enable register stores only bits 3:0 of `ier_wdata`; `ier_rd` returns them in bits 3:0 with bits 7:4 always zero. Bit 0 enables receive data and timeout, bit 1 holding-empty, bit 2 line status, bit 3 modem status.
- R2: The identifier in `iir_q[3:0]` follows a fixed priority, highest first: line status 0x6, character timeout 0xC, received data 0x4, holding empty 0x2, modem status 0x0. The value 0x1 means nothing is pending.
- R3: Line status is raised when enable bit 2 is set and any of `line_stat` bits 4:1 is set (mask 0x1E). Bit 0 (data ready) and bits 7:5 do not raise it.
- R4: A character timeout (`rx_timeout`) is reported only while enable bit 0 is set.
- R5: Received data needs enable bit 0 and `line_stat[0]`. With `fifo_en` high it also needs `rx_count >= rx_trig`; with `fifo_en` low, data ready alone is enough.
- R6: Modem status is raised when enable bit 3 is set and any bit of `msr_delta` is set.
- R7: `iir_q[7:6]` read 11 while `fifo_en` is high and 00 otherwise; `iir_q[5:4]` read 00.
- R8: Pulsing `iir_rd` while `iir_q[3:0]` is 0x2 moves the pending flag to `TP_IDLE`. A read while any other identifier shows leaves the flag unchanged.
- R9: A `thr_done` pulse, or an enable write while `thr_empty` is high, moves the flag to `TP_ARMED`. A `thr_load` pulse moves it to `TP_IDLE`.
- R10: When an arm event and an acknowledging read fall in the same cycle, the flag ends in `TP_ARMED`.
- R11: `irq` and `iir_q` are registered. Each reflects its inputs one clock edge after they change, and `irq` is high exactly when `iir_q[3:0]` is not 0x1.
- R12: During reset `iir_q` is 0x01, `irq` is low, the enable register is zero and the flag is `TP_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rd | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification byte read strobe |
| iir_q | output | 8 | Identification byte |
| line_stat | input | 8 | Line status bits (0 data ready, 4:1 errors) |
| thr_empty | input | 1 | Holding register currently empty |
| thr_done | input | 1 | Pulse: transmitter has emptied the holding register |
| thr_load | input | 1 | Pulse: software loaded the holding register |
| rx_timeout | input | 1 | Character-timeout pending flag |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| fifo_en | input | 1 | FIFOs enabled |
| msr_delta | input | 4 | Modem status delta bits |
| irq | output | 1 | Interrupt request |

## Verification
Two things can collide in one cycle: software acknowledging the empty-holding source, and a fresh arm event from `thr_done` or an enable write. The bench drives `iir_rd` and `thr_done` on the same edge while 0x2 is displayed and expects 0x2 to remain. A lone read afterwards then shows 0x1, which proves the acknowledge itself still works. A second pair of checks reads the byte while a higher-priority source hides 0x2, then removes that source and expects 0x2 to appear.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

    typedef enum logic [3:0] {
        IID_MODEM   = 4'h0,
        IID_NONE    = 4'h1,
        IID_THRE    = 4'h2,
        IID_RXDATA  = 4'h4,
        IID_LINE    = 4'h6,
        IID_TIMEOUT = 4'hC
    } iid_e;

    typedef enum logic {
        TP_IDLE,
        TP_ARMED
    } tp_state_e;

    localparam logic [7:0] LSR_ERR_MASK = 8'h1E;
    localparam int         IER_W        = 4;

endpackage

// File: rtl/uart_iid_ier_reg.sv
module uart_iid_ier_reg
    import uart_iid_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       wdata,
    output logic [IER_W-1:0] ier
);
    logic unused_hi;
    assign unused_hi = ^wdata[7:IER_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ier <= '0;
        end else if (we) begin
            ier <= wdata[IER_W-1:0];
        end
    end
endmodule

// File: rtl/uart_iid_thr_track.sv
module uart_iid_thr_track
    import uart_iid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ack,
    input  logic load,
    output logic pend
);
    tp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_IDLE: begin
                if (arm && !load) begin
                    state_d = TP_ARMED;
                end
            end
            TP_ARMED: begin
                if (load) begin
                    state_d = TP_IDLE;
                end else if (ack && !arm) begin
                    state_d = TP_IDLE;
                end
            end
            default: state_d = TP_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == TP_ARMED);
    end
endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
    import uart_iid_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [IER_W-1:0] ier,
    input  logic [7:0]       line_stat,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             fifo_en,
    input  logic             thr_pend,
    input  logic [3:0]       msr_delta,
    output iid_e             id
);
    logic unused_stat;
    logic line_hit, tmo_hit, rx_hit, thr_hit, msr_hit, level_ok;

    assign unused_stat = ^line_stat[7:5];

    always_comb begin
        level_ok = !fifo_en || (rx_count >= rx_trig);
        line_hit = ier[2] && |(line_stat & LSR_ERR_MASK);
        tmo_hit  = ier[0] && rx_timeout;
        rx_hit   = ier[0] && line_stat[0] && level_ok;
        thr_hit  = ier[1] && thr_pend;
        msr_hit  = ier[3] && |msr_delta;

        if (line_hit)      id = IID_LINE;
        else if (tmo_hit)  id = IID_TIMEOUT;
        else if (rx_hit)   id = IID_RXDATA;
        else if (thr_hit)  id = IID_THRE;
        else if (msr_hit)  id = IID_MODEM;
        else               id = IID_NONE;
    end
endmodule

// File: rtl/uart_iid_enc.sv
module uart_iid_enc
    import uart_iid_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_we,
    input  logic [7:0]       ier_wdata,
    output logic [7:0]       ier_rd,
    input  logic             iir_rd,
    output logic [7:0]       iir_q,
    input  logic [7:0]       line_stat,
    input  logic             thr_empty,
    input  logic             thr_done,
    input  logic             thr_load,
    input  logic             rx_timeout,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] rx_trig,
    input  logic             fifo_en,
    input  logic [3:0]       msr_delta,
    output logic             irq
);
    logic [IER_W-1:0] ier;
    logic             thr_pend;
    logic             arm_evt, ack_evt;
    iid_e             id_next;

    uart_iid_ier_reg u_ier (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ier_we),
        .wdata (ier_wdata),
        .ier   (ier)
    );

    assign ier_rd  = {{(8-IER_W){1'b0}}, ier};
    assign arm_evt = thr_done || (ier_we && thr_empty);
    assign ack_evt = iir_rd && (iir_q[3:0] == IID_THRE);

    uart_iid_thr_track u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm_evt),
        .ack   (ack_evt),
        .load  (thr_load),
        .pend  (thr_pend)
    );

    uart_iid_prio #(.CNT_W(CNT_W)) u_prio (
        .ier        (ier),
        .line_stat  (line_stat),
        .rx_timeout (rx_timeout),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .fifo_en    (fifo_en),
        .thr_pend   (thr_pend),
        .msr_delta  (msr_delta),
        .id         (id_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iir_q <= {4'h0, IID_NONE};
            irq   <= 1'b0;
        end else begin
            iir_q <= {{2{fifo_en}}, 2'b00, id_next};
            irq   <= (id_next != IID_NONE);
        end
    end
endmodule

// File: rtl/uart_iid_checker.sv
module uart_iid_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ier_rd,
    input logic [7:0] line_stat,
    input logic       iir_rd,
    input logic [7:0] iir_q,
    input logic       irq,
    input logic       fifo_en,
    input logic       thr_done,
    input logic       thr_load,
    input logic       thr_pend
);
    AST_IRQ_TRACKS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iir_q[3:0] != 4'h1)); // R11

    AST_LINE_ERR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rd[2] && |(line_stat & 8'h1E)) |=> (iir_q[3:0] == 4'h6)); // R3

    AST_TIMEOUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rd[0] |=> (iir_q[3:0] != 4'hC)); // R4

    AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |=> (iir_q[7:4] == 4'hC)); // R7

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_q[3:0] == 4'h2 && !thr_done && !ier_rd[7]) |=> !thr_pend || $past(thr_load)); // R8

    AST_ARM_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && thr_done && !thr_load) |=> thr_pend); // R10
endmodule

bind uart_iid_enc uart_iid_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_rd    (ier_rd),
    .line_stat (line_stat),
    .iir_rd    (iir_rd),
    .iir_q     (iir_q),
    .irq       (irq),
    .fifo_en   (fifo_en),
    .thr_done  (thr_done),
    .thr_load  (thr_load),
    .thr_pend  (thr_pend)
);

// File: tb/uart_iid_enc_bench.sv
module uart_iid_enc_bench;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_we = 1'b0;
    logic [7:0]       ier_wdata = '0;
    logic [7:0]       ier_rd;
    logic             iir_rd = 1'b0;
    logic [7:0]       iir_q;
    logic [7:0]       line_stat = '0;
    logic             thr_empty = 1'b0;
    logic             thr_done = 1'b0;
    logic             thr_load = 1'b0;
    logic             rx_timeout = 1'b0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [CNT_W-1:0] rx_trig = '0;
    logic             fifo_en = 1'b0;
    logic [3:0]       msr_delta = '0;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_iid_enc u_uart_iid_enc (
        .clk(clk), .rst_n(rst_n), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .ier_rd(ier_rd), .iir_rd(iir_rd), .iir_q(iir_q), .line_stat(line_stat),
        .thr_empty(thr_empty), .thr_done(thr_done), .thr_load(thr_load),
        .rx_timeout(rx_timeout), .rx_count(rx_count), .rx_trig(rx_trig),
        .fifo_en(fifo_en), .msr_delta(msr_delta), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_id(input logic [3:0] ier, input logic err,
        input logic dr, input logic tmo, input logic fen, input logic ge,
        input logic pend, input logic dlt);
        if (ier[2] && err)                    return 4'h6;
        if (ier[0] && tmo)                    return 4'hC;
        if (ier[0] && dr && (!fen || ge))     return 4'h4;
        if (ier[1] && pend)                   return 4'h2;
        if (ier[3] && dlt)                    return 4'h0;
        return 4'h1;
    endfunction

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic write_ier(input logic [7:0] v);
        ier_we = 1'b1; ier_wdata = v;
        @(negedge clk);
        ier_we = 1'b0;
    endtask

    task automatic pulse_done();
        thr_done = 1'b1; @(negedge clk); thr_done = 1'b0;
    endtask

    task automatic pulse_load();
        thr_load = 1'b1; @(negedge clk); thr_load = 1'b0;
    endtask

    task automatic pulse_read();
        iir_rd = 1'b1; @(negedge clk); iir_rd = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R12 reset state
        chk("R12 iir", iir_q, 8'h01);
        chk("R12 irq", {7'b0, irq}, 8'h00);
        chk("R12 ier", ier_rd, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 pend idle", iir_q, 8'h01);

        // R1 upper enable bits ignored
        write_ier(8'hFF);
        chk("R1 ier FF", ier_rd, 8'h0F);
        write_ier(8'hA5);
        chk("R1 ier A5", ier_rd, 8'h05);

        // Sweep: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < 2048; i++) begin
            logic [3:0] e;
            logic err, dr, tmo, fen, ge, pend, dlt;
            logic [3:0] id;
            logic [CNT_W-1:0] trig;
            e = i[3:0]; err = i[4]; dr = i[5]; tmo = i[6]; fen = i[7];
            ge = i[8]; pend = i[9]; dlt = i[10];
            trig = CNT_W'(1 + (i % 14));
            line_stat = {1'b0, i[1], i[1], 5'b0} | {7'b0, dr} |
                        (err ? (8'h02 << (i % 4)) : 8'h00);
            rx_timeout = tmo;
            fifo_en = fen;
            rx_trig = trig;
            rx_count = ge ? (trig + CNT_W'(i[2] ? 0 : 1)) : (trig - 1'b1);
            msr_delta = dlt ? (4'h1 << (i % 4)) : 4'h0;
            ier_we = 1'b1; ier_wdata = {i[3:0] ^ 4'h9, e};
            if (pend) thr_done = 1'b1; else thr_load = 1'b1;
            @(negedge clk);
            ier_we = 1'b0; thr_done = 1'b0; thr_load = 1'b0;
            repeat (2) @(negedge clk);
            id = model_id(e, err, dr, tmo, fen, ge, pend, dlt);
            chk("R2/R3/R4/R5/R6/R7 iir", iir_q, {fen, fen, 2'b00, id});
            chk("R11 irq", {7'b0, irq}, {7'b0, id != 4'h1});
        end

        // Quiet state
        line_stat = '0; rx_timeout = 0; fifo_en = 0; msr_delta = '0;
        rx_count = '0; rx_trig = '0;
        write_ier(8'h00);
        pulse_load();
        settle();

        // R9 enable write while empty arms flag
        thr_empty = 1'b1;
        write_ier(8'h02);
        thr_empty = 1'b0;
        settle();
        chk("R9 arm by ier write", iir_q, 8'h02);
        // R8 acknowledge
        pulse_read();
        settle();
        chk("R8 ack clears", iir_q, 8'h01);
        chk("R8 irq low", {7'b0, irq}, 8'h00);

        // R8 read while another id shows
        pulse_done();
        write_ier(8'h03);
        line_stat = 8'h01;
        settle();
        chk("R8 rx shows", iir_q, 8'h04);
        pulse_read();
        line_stat = 8'h00;
        settle();
        chk("R8 no ack under rx", iir_q, 8'h02);

        // R10 arm and ack together
        thr_done = 1'b1; iir_rd = 1'b1;
        @(negedge clk);
        thr_done = 1'b0; iir_rd = 1'b0;
        settle();
        chk("R10 arm wins", iir_q, 8'h02);
        pulse_read();
        settle();
        chk("R10 control ack", iir_q, 8'h01);

        // R9 load clears
        pulse_done();
        settle();
        chk("R9 thr_done arms", iir_q, 8'h02);
        pulse_load();
        settle();
        chk("R9 load clears", iir_q, 8'h01);

        // R11 one-edge latency
        write_ier(8'h08);
        settle();
        msr_delta = 4'h4;
        #1;
        chk("R11 before edge", {7'b0, irq}, 8'h00);
        @(negedge clk);
        chk("R11 irq after edge", {7'b0, irq}, 8'h01);
        chk("R11 iir after edge", iir_q, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule